// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

This block is a register-mapped event timer. A 32-bit main counter steps by one on every clock while the global run bit is set, and a small set of comparator channels watch it. When the counter equals a channel's comparator, the channel raises an interrupt. The interrupt is either a one-cycle pulse (edge type) or a level held through a per-channel status bit until software clears it. A channel runs in one-shot mode or in periodic mode. In periodic mode the channel adds a stored period to its comparator at every match, so it keeps firing with no software help.

Software reaches every word through a plain 32-bit write strobe and a combinational read port; the read port returns data in the same cycle as the address. A 5-bit route field in each channel selects which of 32 interrupt lines it drives. A global legacy bit overrides the route fields of the first two channels and sends them to lines 0 and 8. In periodic mode the comparator is loaded with a two-write sequence. Setting the arm bit makes the next comparator write the match value and the write after it the period.

Top module: `evt_timer`

## Requirements
- R1: After reset the global word, the counter, the status word and all interrupt lines read 0. Each channel config word reads only its periodic-capable bit (bit 4 = 1).
- R2: Reading offset 0x00 returns the vendor identifier in bits 31:16, the channel count minus one in bits 12:8 and the revision in bits 7:0. Reading offset 0x04 returns the nonzero tick period in femtoseconds.
- R3: While bit 0 (run) of the global word at 0x10 is 1, the counter at 0xF0 rises by exactly one per clock. While run is 0 the counter holds and no channel matches.
- R4: A write to the counter loads it only while run is 0. Such a write made while run is 1 is ignored.
- R5: A one-shot (config bit 3 = 0), level-type (bit 1 = 1), enabled (bit 2 = 1) channel n sets status bit n at offset 0x20 one clock after the counter equals its comparator. Its routed line then stays high until that bit is cleared.
- R6: Writing 1 to a status bit clears it and drops the level line. Writing 0 leaves it unchanged.
- R7: An enabled edge-type channel (bit 1 = 0) drives a one-clock pulse on its line one clock after each match and never sets its status bit.
- R8: Writing a config word with bit 6 = 1 and bit 3 = 1 arms the two-write load: the next comparator write sets the match value and the following one sets the period. Bit 6 reads 1 until the period is loaded, then reads 0.
- R9: In periodic mode every match adds the period to the comparator, so pulses repeat every period clocks.
- R10: A channel with bit 2 = 0 drives no line and sets no status bit, yet its comparator still advances on each periodic match.
- R11: Config bits 13:9 select the interrupt line. With bit 1 (legacy) of the global word set, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold.
- R12: Matching is by equality with wrap modulo 2^32: a comparator already passed does not fire, and one just past the wrap point fires after the counter wraps.
- Channel n config sits at 0x100 + 0x20·n and its comparator at 0x108 + 0x20·n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter ticks on it |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_lines | output | 32 | Interrupt lines, one per route value |

## Verification
The compare path is driven with random start counts, distances, periods and routes on edge-type periodic channels. Each case checks the exact clock of the first three pulses and that no other line moves, which separates off-by-one compare timing, wrong reload arithmetic and misrouting. Directed cases cover the rest: a level one-shot with write-0 and write-1 clears, a disabled periodic channel whose comparator must still advance, the arm-bit readback across both writes, a counter write while running, the legacy override against a conflicting route, and a comparator placed just past the wrap point beside one already passed.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam logic [11:0] OFS_CAP   = 12'h000;
  localparam logic [11:0] OFS_PER   = 12'h004;
  localparam logic [11:0] OFS_GEN   = 12'h010;
  localparam logic [11:0] OFS_STS   = 12'h020;
  localparam logic [11:0] OFS_CNT   = 12'h0F0;
  localparam logic [3:0]  CH_PAGE   = 4'h1;
  localparam logic [4:0]  CH_CFG    = 5'h00;
  localparam logic [4:0]  CH_CMP    = 5'h08;

  localparam int GEN_RUN = 0;
  localparam int GEN_LEG = 1;

  localparam int C_LEVEL  = 1;
  localparam int C_IE     = 2;
  localparam int C_PER    = 3;
  localparam int C_PCAP   = 4;
  localparam int C_VS     = 6;
  localparam int C_F32    = 8;
  localparam int C_RT_LSB = 9;
  localparam int RT_W     = 5;

  typedef enum logic [1:0] {
    VS_IDLE   = 2'd0,
    VS_MATCH  = 2'd1,
    VS_PERIOD = 2'd2
  } vs_state_e;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (run)    cnt <= cnt + 1'b1;
    else if (ld)     cnt <= ld_val;
  end

  // R3: one step per clock while running
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cnt == $past(cnt) + 1'b1));
  // R3: frozen when stopped and not loaded
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(cnt));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [W-1:0]    cnt,
  input  logic            cfg_wr,
  input  logic            cmp_wr,
  input  logic [W-1:0]    wdata,
  input  logic            sts_clr,
  output logic [W-1:0]    cfg_rd,
  output logic [W-1:0]    cmp_rd,
  output logic            sts,
  output logic            fire,
  output logic [RT_W-1:0] route
);
  logic          ie, lvl, per_md, f32;
  logic [W-1:0]  cmp, period;
  logic          pulse;
  vs_state_e     stage;
  logic          match;

  assign match = run && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie     <= 1'b0;
      lvl    <= 1'b0;
      per_md <= 1'b0;
      f32    <= 1'b0;
      route  <= '0;
    end else if (cfg_wr) begin
      ie     <= wdata[C_IE];
      lvl    <= wdata[C_LEVEL];
      per_md <= wdata[C_PER];
      f32    <= wdata[C_F32];
      route  <= wdata[C_RT_LSB +: RT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp    <= '0;
      period <= '0;
      stage  <= VS_IDLE;
    end else begin
      if (cfg_wr && wdata[C_VS]) stage <= VS_MATCH;
      if (cmp_wr) begin
        if (per_md && stage == VS_MATCH) begin
          cmp   <= wdata;
          stage <= VS_PERIOD;
        end else if (per_md && stage == VS_PERIOD) begin
          period <= wdata;
          stage  <= VS_IDLE;
        end else begin
          cmp <= wdata;
        end
      end else if (match && per_md) begin
        cmp <= cmp + period;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts   <= 1'b0;
      pulse <= 1'b0;
    end else begin
      if (match && ie && lvl) sts <= 1'b1;
      else if (sts_clr)       sts <= 1'b0;
      pulse <= match && ie && !lvl;
    end
  end

  assign fire = lvl ? (sts && ie) : pulse;

  always_comb begin
    cfg_rd                      = '0;
    cfg_rd[C_LEVEL]             = lvl;
    cfg_rd[C_IE]                = ie;
    cfg_rd[C_PER]               = per_md;
    cfg_rd[C_PCAP]              = 1'b1;
    cfg_rd[C_VS]                = (stage != VS_IDLE);
    cfg_rd[C_F32]               = f32;
    cfg_rd[C_RT_LSB +: RT_W]    = route;
  end
  assign cmp_rd = cmp;

  // R9: periodic match advances comparator by the period
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (match && per_md && !cmp_wr) |=> (cmp == $past(cmp) + $past(period)));
  // R10: disabled channel emits no pulse
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |=> !pulse);
  // R7: edge-type channel never raises its status bit
  a_r7_no_status: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl && !sts) |=> !sts);
  // R8: period write ends the two-write load
  a_r8_vs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (per_md && stage == VS_PERIOD && cmp_wr && !cfg_wr) |=> (stage == VS_IDLE));
  // R3: stopped counter leaves comparator untouched
  a_r3_no_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cmp_wr) |=> $stable(cmp));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_pkg::*;
#(
  parameter int          NCHAN     = 3,
  parameter logic [15:0] VENDOR    = 16'h5A17,
  parameter logic [7:0]  REV       = 8'h02,
  parameter logic [31:0] PERIOD_FS = 32'd50_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [31:0] irq_lines
);
  localparam int W     = 32;
  localparam int CIW   = 3;
  localparam int LINES = 1 << RT_W;

  logic             g_run, g_leg;
  logic [W-1:0]     cnt;
  logic             cnt_ld;
  logic             in_ch;
  logic [CIW-1:0]   ch_idx;
  logic [4:0]       ch_off;
  logic             sts_wr;

  logic [NCHAN-1:0] cfg_wr, cmp_wr, sts_clr, sts, fire;
  logic [W-1:0]     cfg_rd [NCHAN];
  logic [W-1:0]     cmp_rd [NCHAN];
  logic [RT_W-1:0]  route  [NCHAN];

  assign in_ch  = (addr[11:8] == CH_PAGE);
  assign ch_idx = addr[7:5];
  assign ch_off = addr[4:0];
  assign sts_wr = wr_en && (addr == OFS_STS);
  assign cnt_ld = wr_en && (addr == OFS_CNT) && !g_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_run <= 1'b0;
      g_leg <= 1'b0;
    end else if (wr_en && addr == OFS_GEN) begin
      g_run <= wdata[GEN_RUN];
      g_leg <= wdata[GEN_LEG];
    end
  end

  evt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(g_run),
    .ld(cnt_ld), .ld_val(wdata), .cnt(cnt)
  );

  for (genvar i = 0; i < NCHAN; i++) begin : g_ch
    assign cfg_wr[i]  = wr_en && in_ch && (ch_idx == CIW'(i)) && (ch_off == CH_CFG);
    assign cmp_wr[i]  = wr_en && in_ch && (ch_idx == CIW'(i)) && (ch_off == CH_CMP);
    assign sts_clr[i] = sts_wr && wdata[i];
    evt_channel #(.W(W)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(g_run), .cnt(cnt),
      .cfg_wr(cfg_wr[i]), .cmp_wr(cmp_wr[i]), .wdata(wdata),
      .sts_clr(sts_clr[i]), .cfg_rd(cfg_rd[i]), .cmp_rd(cmp_rd[i]),
      .sts(sts[i]), .fire(fire[i]), .route(route[i])
    );
  end

  always_comb begin
    irq_lines = '0;
    for (int i = 0; i < NCHAN; i++) begin
      if (fire[i]) begin
        if (g_leg && i == 0)      irq_lines[0] = 1'b1;
        else if (g_leg && i == 1) irq_lines[8] = 1'b1;
        else                      irq_lines[route[i]] = 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CAP: rdata = {VENDOR, 3'b000, 5'(NCHAN - 1), REV};
      OFS_PER: rdata = PERIOD_FS;
      OFS_GEN: rdata = {30'd0, g_leg, g_run};
      OFS_STS: rdata = W'(sts);
      OFS_CNT: rdata = cnt;
      default: begin
        for (int i = 0; i < NCHAN; i++) begin
          if (in_ch && ch_idx == CIW'(i) && ch_off == CH_CFG) rdata = cfg_rd[i];
          if (in_ch && ch_idx == CIW'(i) && ch_off == CH_CMP) rdata = cmp_rd[i];
        end
      end
    endcase
  end

  // R4: counter write ignored while running
  a_r4_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (g_run && wr_en && addr == OFS_CNT) |=> (cnt == $past(cnt) + 1'b1));
  // R6: write-1 clears a status bit not being set
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && wdata[0] && !g_run) |=> !sts[0]);
  // R11: legacy override sends channel 0 to line 0
  a_r11_legacy: assert property (@(posedge clk) disable iff (!rst_n)
    (g_leg && fire[0]) |-> irq_lines[0]);
  // R1: no line active while everything is quiet after reset
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (fire == '0) |-> (irq_lines == '0));
  initial a_r2_lines: assert (LINES == 32 && NCHAN <= 8 && NCHAN >= 2);
endmodule

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
  localparam int CLK_NS = 10;
  localparam int NCH    = 3;
  localparam logic [15:0] VEN = 16'h5A17;
  localparam logic [7:0]  RV  = 8'h02;
  localparam logic [31:0] PFS = 32'd50_000_000;
  localparam logic [11:0] A_CAP = 12'h000, A_PER = 12'h004, A_GEN = 12'h010,
                          A_STS = 12'h020, A_CNT = 12'h0F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, irq_lines;
  int n_chk = 0, n_fail = 0;
  logic [31:0] v, v2;
  int t, oth;

  evt_timer #(.NCHAN(NCH), .VENDOR(VEN), .REV(RV), .PERIOD_FS(PFS)) u_evt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_lines(irq_lines)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [11:0] a_cfg(int ch); return 12'h100 + 12'(ch * 32); endfunction
  function automatic logic [11:0] a_cmp(int ch); return 12'h108 + 12'(ch * 32); endfunction
  function automatic logic [31:0] cfgw(bit lvl, bit ie, bit per, bit vs, int rt);
    return (32'(lvl) << 1) | (32'(ie) << 2) | (32'(per) << 3) | (32'(vs) << 6) | (32'(rt) << 9);
  endfunction
  function automatic int first_fire(logic [31:0] c0, logic [31:0] cmp);
    return int'(cmp - c0) + 1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic clr_all();
    wr(A_GEN, 0);
    for (int c = 0; c < NCH; c++) wr(a_cfg(c), 0);
    wr(A_STS, 32'hFFFF_FFFF);
    wr(A_CNT, 0);
  endtask

  // waits up to mx clocks for line ln; t = clocks counted, oth = other-line hits
  task automatic wait_line(int ln, int mx, output int tt, output int ot);
    tt = -1; ot = 0;
    for (int j = 1; j <= mx; j++) begin
      @(negedge clk);
      if ((irq_lines & ~(32'd1 << ln)) != 0) ot++;
      if (irq_lines[ln]) begin tt = j; break; end
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    v = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_GEN, v); chk("R1 gen", v, 0);
    rd(A_CNT, v); chk("R1 cnt", v, 0);
    rd(A_STS, v); chk("R1 sts", v, 0);
    rd(a_cfg(0), v); chk("R1 cfg", v, 32'h10);
    chk("R1 irq", irq_lines, 0);

    // R2 identification
    rd(A_CAP, v); chk("R2 cap", v, {VEN, 8'(NCH - 1), RV});
    rd(A_PER, v); chk("R2 period", v, PFS);

    // R5 / R6 level one-shot
    clr_all();
    wr(a_cfg(0), cfgw(1, 1, 0, 0, 4));
    wr(a_cmp(0), 110);
    wr(A_CNT, 100);
    wr(A_GEN, 1);
    wait_line(4, 60, t, oth);
    chk("R5 fire time", t, first_fire(100, 110));
    repeat (5) @(negedge clk);
    chk("R5 held", irq_lines[4], 1);
    rd(A_STS, v); chk("R5 status", v, 1);
    wr(A_STS, 0);
    rd(A_STS, v); chk("R6 write0", v, 1);
    wr(A_STS, 1);
    rd(A_STS, v); chk("R6 write1", v, 0);
    chk("R6 line low", irq_lines[4], 0);

    // R4 counter write while running
    rd(A_CNT, v);
    wr(A_CNT, 0);
    rd(A_CNT, v2); chk("R4 ignored", v2, v + 3);

    // R8 two-write load and readback
    clr_all();
    wr(a_cfg(1), cfgw(0, 0, 1, 1, 6));
    rd(a_cfg(1), v); chk("R8 armed", v[6], 1);
    wr(a_cmp(1), 10);
    rd(a_cfg(1), v); chk("R8 mid", v[6], 1);
    wr(a_cmp(1), 7);
    rd(a_cfg(1), v); chk("R8 done", v[6], 0);
    rd(a_cmp(1), v); chk("R8 match value", v, 10);

    // R10 disabled periodic channel still reloads
    wr(A_GEN, 1);
    oth = 0;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      if (irq_lines != 0) oth++;
    end
    wr(A_GEN, 0);
    chk("R10 no line", oth, 0);
    rd(a_cmp(1), v); chk("R10 cmp advanced", v, 24);
    rd(A_CNT, v); chk("R3 stopped count", v, 22);
    repeat (4) @(negedge clk);
    rd(A_CNT, v2); chk("R3 frozen", v2, 22);
    rd(A_STS, v); chk("R10 no status", v, 0);

    // R9 / R7 / R11 random periodic edge channels
    for (int it = 0; it < 12; it++) begin
      int ch, d, per, rt, tt, ot, last;
      logic [31:0] c0;
      ch  = int'($urandom_range(NCH - 1, 0));
      d   = int'($urandom_range(40, 3));
      per = int'($urandom_range(30, 2));
      rt  = int'($urandom_range(31, 0));
      c0  = $urandom;
      clr_all();
      wr(a_cfg(ch), cfgw(0, 1, 1, 1, rt));
      wr(a_cmp(ch), c0 + 32'(d));
      wr(a_cmp(ch), 32'(per));
      wr(A_CNT, c0);
      wr(A_GEN, 1);
      wait_line(rt, d + 10, tt, ot);
      chk("R9 first pulse", tt, first_fire(c0, c0 + 32'(d)));
      chk("R11 route exclusive", ot, 0);
      last = tt;
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk("R7 one cycle", irq_lines[rt], 0);
        wait_line(rt, per + 5, tt, ot);
        chk("R9 period", tt + 1, per);
      end
      rd(A_STS, v); chk("R7 no status", v, 0);
    end

    // R11 legacy override
    clr_all();
    wr(a_cfg(1), cfgw(0, 1, 0, 0, 3));
    wr(a_cmp(1), 5);
    wr(A_GEN, 3);
    wait_line(8, 30, t, oth);
    chk("R11 legacy line8", t, first_fire(0, 5));
    chk("R11 route ignored", oth, 0);

    // R12 wrap and passed comparator
    clr_all();
    wr(a_cfg(2), cfgw(0, 1, 0, 0, 20));
    wr(a_cmp(2), 5);
    wr(A_CNT, 32'hFFFF_FFF0);
    wr(A_GEN, 1);
    wait_line(20, 60, t, oth);
    chk("R12 wrap fire", t, first_fire(32'hFFFF_FFF0, 5));
    clr_all();
    wr(a_cfg(2), cfgw(0, 1, 0, 0, 20));
    wr(a_cmp(2), 40);
    wr(A_CNT, 50);
    wr(A_GEN, 1);
    wait_line(20, 100, t, oth);
    chk("R12 passed no fire", t, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule